// File: doc/BRIEF.md
# MDIO Management Register Controller

This block is one memory-mapped 32-bit command/status word that runs clause-22 management transactions to an external PHY. Software writes one word that holds the PHY address, the register address, the write data and a start bit. The block then serialises a complete management frame on MDC/MDIO, with an output enable for the shared MDIO line. While the frame runs, a busy flag reads as set. When a read completes, the 16-bit result and a not-valid flag can be read back from the same word.

MDC is made from the system clock by a parameterised divider. The divider runs only while a transaction is in flight. The PHY address field has a parameterised reset value, so software can find the attached PHY before it issues any command.

Top module: `mdio_mgmt_reg`

## Requirements
- R1: After reset, rd_data equals PHY_ADDR_RST placed in bits 15:11 with every other bit 0. MDC is low and mdio_oe is low.
- R2: Word layout: PHY address in bits 15:11, register address in bits 10:6, data in bits 31:16, busy in bit 3, not-valid in bit 4. Bits 1:0 always read as 0. An accepted write always loads bits 31:16, 15:11 and 10:6. With bit 1 set it starts a read; otherwise, with bit 0 set, it starts a write. With neither bit set it only updates the fields and starts nothing.
- R3: Busy reads as 1 from the cycle after a start is accepted, for exactly 128*DIV_HALF clock cycles, then reads 0.
- R4: The frame is sent MSB first. It is 32 ones, then start 01, then opcode (10 for a read, 01 for a write), then 5 PHY address bits, then 5 register address bits. A write continues with turnaround 10 and the 16 data bits. mdio_oe is high for all 64 bits.
- R5: On a read, mdio_oe is high for the first 46 bits and low for the last 18 bits (turnaround and data).
- R6: When a read completes and the PHY drove 0 in the second turnaround bit, bits 31:16 hold the 16 data bits sampled MSB first and bit 4 is 0.
- R7: When a read completes and MDIO was 1 in the second turnaround bit, bit 4 is 1. The data field holds whatever was sampled, which is all ones on an idle-high line.
- R8: MDC is low between transactions. During a transaction each MDC half period lasts DIV_HALF clock cycles and there are exactly 64 rising edges. MDIO output changes only on falling MDC edges.
- R9: A write to the word while busy is set has no effect on the fields, the running frame or its duration.
- R10: After a write transaction completes, bits 31:16 still hold the data that was written, and not-valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the management word |
| wr_data | input | 32 | Value written to the management word |
| rd_data | output | 32 | Current management word (fields, busy, not-valid) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench uses a PHY model that answers reads at a single address. Random mixes of reads and writes with random PHY and register addresses and data are checked against frames built by bench functions, bit by bit and with the output-enable pattern. Reads sent to the model's own address check data capture. Reads sent to other addresses, or to a muted model, leave the turnaround high and so separate the valid case from the not-valid one. Directed cases cover the reset readback, a field-only write, both start bits set together, and a second write while busy, which must change neither the fields nor the busy length.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int WORD_W    = 32;
  localparam int FRAME_LEN = 64;
  localparam int FRAME_CW  = $clog2(FRAME_LEN);
  localparam int DATA_LSB  = 16;
  localparam int PHY_LSB   = 11;
  localparam int REG_LSB   = 6;
  localparam int NVAL_BIT  = 4;
  localparam int BUSY_BIT  = 3;
  localparam int RD_BIT    = 1;
  localparam int WR_BIT    = 0;
  // bit index of the last driven bit on a read, and of the sampled turnaround bit
  localparam int RD_LAST_DRIVEN = 45;
  localparam int TA_SAMPLE_BIT  = 47;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic       is_read,
    input logic [4:0] phy,
    input logic [4:0] regad,
    input logic [15:0] wdata);
    build_frame = {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01), phy, regad,
                   (is_read ? 2'b11 : 2'b10), (is_read ? 16'hFFFF : wdata)};
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic tick;
  logic mdc_q, mdc_d;

  generate
    if (DIV_HALF <= 1) begin : g_fast
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV_HALF);
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = cnt_q;
        if (!run)     cnt_d = '0;
        else if (tick) cnt_d = '0;
        else          cnt_d = cnt_q + 1'b1;
      end
      assign tick = run && (cnt_q == CW'(DIV_HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb begin
    mdc_d = mdc_q;
    if (!run)      mdc_d = 1'b0;
    else if (tick) mdc_d = ~mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc       = mdc_q;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        done_rd,
  output logic [15:0] rdata,
  output logic        rd_bad
);
  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic                 oe_q, oe_d;
  logic [FRAME_CW-1:0]  idx_q, idx_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [15:0]          in_q, in_d;
  logic                 bad_q, bad_d;
  logic                 last_fall;

  assign last_fall = busy_q && fall_tick && (idx_q == FRAME_CW'(FRAME_LEN - 1));

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    in_d   = in_q;
    bad_d  = bad_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      oe_d   = 1'b1;
      idx_d  = '0;
      sh_d   = build_frame(start_rd, phy, regad, wdata);
      bad_d  = 1'b0;
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (idx_q == FRAME_CW'(TA_SAMPLE_BIT)) bad_d = mdio_i;
        if (idx_q > FRAME_CW'(TA_SAMPLE_BIT))  in_d  = {in_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (last_fall) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_LEN-2:0], 1'b1};
          if (rd_q && idx_q == FRAME_CW'(RD_LAST_DRIVEN)) oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      in_q   <= '0;
      bad_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      in_q   <= in_d;
      bad_q  <= bad_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = oe_q ? sh_q[FRAME_LEN-1] : 1'b0;
  assign mdio_oe = oe_q;
  assign done    = last_fall;
  assign done_rd = last_fall && rd_q;
  assign rdata   = in_q;
  assign rd_bad  = bad_q;
endmodule

// File: rtl/mdio_mgmt_reg.sv
module mdio_mgmt_reg
  import mdio_mgmt_pkg::*;
#(
  parameter int         DIV_HALF     = 4,
  parameter logic [4:0] PHY_ADDR_RST = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [4:0]  phy_q, phy_d;
  logic [4:0]  reg_q, reg_d;
  logic [15:0] dat_q, dat_d;
  logic        nval_q, nval_d;
  logic        busy, accept, start, start_rd;
  logic        rise_tick, fall_tick, done, done_rd, rd_bad;
  logic [15:0] rdata;
  logic        unused_bits;

  assign unused_bits = ^{wr_data[5:2], done};
  assign accept   = wr_en && !busy;
  assign start_rd = wr_data[RD_BIT];
  assign start    = accept && (wr_data[RD_BIT] || wr_data[WR_BIT]);

  always_comb begin
    phy_d  = phy_q;
    reg_d  = reg_q;
    dat_d  = dat_q;
    nval_d = nval_q;
    if (accept) begin
      phy_d = wr_data[PHY_LSB +: 5];
      reg_d = wr_data[REG_LSB +: 5];
      dat_d = wr_data[DATA_LSB +: 16];
      if (start) nval_d = 1'b0;
    end else if (done_rd) begin
      dat_d  = rdata;
      nval_d = rd_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= PHY_ADDR_RST;
      reg_q  <= '0;
      dat_q  <= '0;
      nval_q <= 1'b0;
    end else begin
      phy_q  <= phy_d;
      reg_q  <= reg_d;
      dat_q  <= dat_d;
      nval_q <= nval_d;
    end
  end

  mdc_divider #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .phy(wr_data[PHY_LSB +: 5]), .regad(wr_data[REG_LSB +: 5]),
    .wdata(wr_data[DATA_LSB +: 16]),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .done_rd(done_rd), .rdata(rdata), .rd_bad(rd_bad)
  );

  always_comb begin
    rd_data = '0;
    rd_data[DATA_LSB +: 16] = dat_q;
    rd_data[PHY_LSB +: 5]   = phy_q;
    rd_data[REG_LSB +: 5]   = reg_q;
    rd_data[NVAL_BIT]       = nval_q;
    rd_data[BUSY_BIT]       = busy;
  end
endmodule

// File: rtl/mdio_mgmt_reg_chk.sv
module mdio_mgmt_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |-> !mdc);                                                // R8
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[3] |-> !mdio_oe);                                            // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[3] && wr_en && (wr_data[1] || wr_data[0])) |=> rd_data[3]); // R3
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && wr_en) |=> $stable(rd_data[15:6]));                    // R9
  AST_NO_CHANGE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && $rose(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
  AST_OP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1:0] == 2'b00);                                               // R2
endmodule

bind mdio_mgmt_reg mdio_mgmt_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_reg_test.sv
module mdio_mgmt_reg_test;
  localparam int         DIV_HALF = 2;
  localparam logic [4:0] RST_PHY  = 5'd1;
  localparam logic [4:0] MODEL_PHY = 5'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails  = 0;
  bit hung   = 0;

  logic seen [0:63];
  logic seen_oe [0:63];
  int   rise_cnt = 0;
  int   mdc_high_cyc = 0;
  logic phy_en = 1'b0, phy_val = 1'b1, phy_mute = 1'b0;
  logic [15:0] phy_resp = 16'h0;

  always #2.5 clk = ~clk;

  mdio_mgmt_reg #(.DIV_HALF(DIV_HALF), .PHY_ADDR_RST(RST_PHY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      seen[rise_cnt]    = mdio_i;
      seen_oe[rise_cnt] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge clk) if (mdc) mdc_high_cyc = mdc_high_cyc + 1;

  // PHY model: answers reads at MODEL_PHY, changes its output on falling MDC
  always @(negedge mdc) begin
    logic [4:0] a;
    for (int k = 0; k < 5; k++) a[4-k] = seen[36+k];
    if (!phy_mute && seen[34] == 1'b1 && seen[35] == 1'b0 && a == MODEL_PHY &&
        rise_cnt >= 47 && rise_cnt <= 63) begin
      phy_en  = 1'b1;
      phy_val = (rise_cnt == 47) ? 1'b0 : phy_resp[63-rise_cnt];
    end else begin
      phy_en = 1'b0;
    end
  end

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    exp_frame = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] d, input logic [4:0] p,
                                           input logic [4:0] r, input logic nv);
    exp_word = {d, p, r, 1'b0, nv, 1'b0, 3'b000};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue a command and count busy cycles until it drops
  task automatic run_cmd(input logic [31:0] w, output int busy_cyc);
    int guard = 0;
    rise_cnt = 0; mdc_high_cyc = 0;
    write_word(w);
    busy_cyc = 0;
    while (rd_data[3] === 1'b1 && guard < 20000) begin
      busy_cyc++; guard++;
      @(negedge clk);
    end
    if (guard >= 20000) begin
      hung = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  endtask

  task automatic do_txn(input logic rd, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d);
    int bc;
    logic [63:0] ef, got, goe, eoe;
    logic [15:0] exp_d;
    logic exp_nv;
    run_cmd({d, p, r, 4'b0, rd, ~rd}, bc);
    if (hung) return;
    check("R3 busy length", 64'(bc), 64'(128*DIV_HALF));
    check("R8 rising edges", 64'(rise_cnt), 64'd64);
    check("R8 high time", 64'(mdc_high_cyc), 64'(64*DIV_HALF));
    ef = exp_frame(rd, p, r, d);
    for (int k = 0; k < 64; k++) begin
      got[63-k] = seen[k];
      goe[63-k] = seen_oe[k];
    end
    if (rd) begin
      check("R4 read header", 64'(got[63:18]), 64'(ef[63:18]));
      eoe = {{46{1'b1}}, 18'b0};
      check("R5 read oe pattern", goe, eoe);
      if (!phy_mute && p == MODEL_PHY) begin exp_d = phy_resp; exp_nv = 1'b0; end
      else begin exp_d = 16'hFFFF; exp_nv = 1'b1; end
      check(exp_nv ? "R7 read invalid word" : "R6 read valid word",
            64'(rd_data), 64'(exp_word(exp_d, p, r, exp_nv)));
    end else begin
      check("R4 write frame", got, ef);
      check("R4 write oe pattern", goe, {64{1'b1}});
      check("R10 write word after", 64'(rd_data), 64'(exp_word(d, p, r, 1'b0)));
    end
  endtask

  initial begin
    int bc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset word", 64'(rd_data), 64'(exp_word(16'h0, RST_PHY, 5'd0, 1'b0)));
    check("R1 reset pins", 64'({mdc, mdio_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after release", 64'(rd_data), 64'(exp_word(16'h0, RST_PHY, 5'd0, 1'b0)));

    // R2 field-only write, no start
    write_word({16'hBEEF, 5'd9, 5'd3, 6'b0});
    repeat (4) @(negedge clk);
    check("R2 field update no busy", 64'(rd_data), 64'(exp_word(16'hBEEF, 5'd9, 5'd3, 1'b0)));
    check("R2 no mdc activity", 64'({mdc, mdio_oe}), 64'd0);

    // directed: valid read, write, invalid read (other address), muted read
    phy_resp = 16'hA5C3;
    do_txn(1'b1, MODEL_PHY, 5'd2, 16'h0);
    do_txn(1'b0, 5'd20, 5'd31, 16'h8001);
    do_txn(1'b1, 5'd8, 5'd1, 16'h0);
    phy_mute = 1'b1;
    do_txn(1'b1, MODEL_PHY, 5'd1, 16'h0);
    phy_mute = 1'b0;

    // R2 both start bits: read wins
    phy_resp = 16'h1234;
    run_cmd({16'hFFFF, MODEL_PHY, 5'd4, 6'b000011}, bc);
    check("R2 both bits read wins", 64'(rd_data), 64'(exp_word(16'h1234, MODEL_PHY, 5'd4, 1'b0)));
    check("R2 read opcode seen", 64'({seen[34], seen[35]}), 64'(2'b10));

    // R9 write during busy is ignored
    begin
      int guard = 0;
      int cnt = 0;
      rise_cnt = 0;
      write_word({16'h5555, 5'd11, 5'd12, 6'b000001});
      repeat (40) @(negedge clk);
      cnt = 41;
      write_word({16'h0F0F, 5'd30, 5'd29, 6'b000010});
      check("R9 fields kept mid-busy", 64'(rd_data[15:6]), 64'({5'd11, 5'd12}));
      cnt++;
      while (rd_data[3] === 1'b1 && guard < 20000) begin cnt++; guard++; @(negedge clk); end
      check("R9 busy length unchanged", 64'(cnt), 64'(128*DIV_HALF));
      check("R9 word after", 64'(rd_data), 64'(exp_word(16'h5555, 5'd11, 5'd12, 1'b0)));
    end

    // random mix
    for (int n = 0; n < 14 && !hung; n++) begin
      logic rd;
      logic [4:0] p, r;
      logic [15:0] d;
      rd = 1'($urandom_range(0, 1));
      p  = ($urandom_range(0, 2) == 0) ? 5'($urandom) : MODEL_PHY;
      r  = 5'($urandom);
      d  = 16'($urandom);
      phy_resp = 16'($urandom);
      do_txn(rd, p, r, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule